// File: doc/BRIEF.md
# Key-Guarded Watchdog and Interval Timer

An 8-bit up-counter driven from a programmable clock divider. Depending on its mode it either guards the chip or produces periodic interrupts. Software reaches it through a small register port that accepts only full 16-bit writes. The counter and the control register share one write address. The upper byte of the written word is a key that picks which of the two is loaded; any other key leaves both unchanged. A separate status register holds a sticky overflow flag and a reset-enable bit. The flag survives the chip reset that the block itself issues, so firmware can tell a watchdog restart from a power-on.

In watchdog mode, a wrap of the counter from 0xFF to 0x00 sets the flag. If reset-enable is set, the block then drives a chip-reset pulse of fixed length. If it is clear, the block only returns its own counter and control register to their power-on values. In interval mode, each wrap gives a one-cycle interrupt pulse and the counter keeps running.

The main state machine has four states. ST_OFF means stopped. ST_WATCH and ST_INTERVAL mean running in watchdog or interval mode. ST_RSTOUT means the chip-reset pulse is being driven. A control write moves ST_OFF, ST_WATCH and ST_INTERVAL among one another. A watchdog wrap moves ST_WATCH to ST_RSTOUT when reset-enable is 1, or to ST_OFF when it is 0. ST_RSTOUT returns to ST_OFF when its cycle count runs out. A second machine guards the flag-clear handshake. It moves from ARM_IDLE to ARM_SET when the status register is read while the flag is 1, and back to ARM_IDLE on any accepted status write.

Top module: `keyed_watchdog`

## Requirements
- R1: A write with bus_word low (byte access) changes no register, whatever its key.
- R2: A word write to address 0 with upper byte 0x5A loads the lower byte into the counter. With upper byte 0xA5 it loads the control register. Any other upper byte changes neither.
- R3: While enabled, the counter advances by one every N system clocks, where N is 2, 8, 32, 64, 256, 512, 2048 or 4096 for clock-select values 0 to 7. The first step comes N clocks after the enabling write. While disabled, the counter holds its value.
- R4: In watchdog mode, a counter wrap from 0xFF to 0x00 sets the overflow flag (status bit 7). A wrap in interval mode never sets it.
- R5: The flag clears only on a word write to address 2, with key 0x5A and data bit 7 = 0, that follows a read of address 2 which returned the flag as 1. A write of 0 without that prior read leaves the flag set.
- R6: Status reads from address 2 as {flag, reset-enable, 0, 5'b11111}. A key-0x5A word write to address 2 sets reset-enable from data bit 6. Bits 5 to 0 cannot be changed, and a write with any other key is ignored.
- R7: A watchdog wrap with reset-enable = 1 drives chip_rst_o high for exactly 518 clocks, starting the cycle after the wrap. During that pulse, counter and control read 0x00. The flag stays set after the pulse.
- R8: A watchdog wrap with reset-enable = 0 never raises chip_rst_o. It returns the counter and control register to 0x00, which stops the timer.
- R9: In interval mode, each wrap drives irq_o high for exactly one clock, in the cycle after the wrap, and the counter keeps counting from 0x00.
- R10: After power-on reset the counter and the control register read 0x00 and the status register reads 0x1F. chip_rst_o and irq_o are low.
- R11: The control register, read at address 1, has this layout: bit 7 is the mode (1 = watchdog, 0 = interval), bit 6 is enable, bits 2:0 are the clock select, and bits 5:3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 2 | 0 = counter/control, 1 = control read, 2 = status |
| bus_wdata | input | 16 | Write data: key in [15:8], value in [7:0] |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| chip_rst_o | output | 1 | Chip-reset pulse after a watchdog wrap |
| irq_o | output | 1 | One-cycle interval interrupt |

## Verification
Register writes take effect at the clock edge that samples the strobe. Reads are combinational, so every readback is sampled half a cycle after the access is driven. The counter's first step is due exactly N edges after the enabling write, and a wrap shows on chip_rst_o or irq_o one edge later. The bench therefore drives on falling edges and counts falling edges from the edge that sampled the enabling write to the cycle where each result must first appear. It samples the cycle before as well, so a result that comes one clock early or late is caught. The 518-cycle pulse is measured by counting every falling edge at which chip_rst_o is high.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam logic [7:0] KEY_COUNT = 8'h5A;
    localparam logic [7:0] KEY_CTRL  = 8'h A5;

    localparam logic [1:0] ADDR_MAIN = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_WATCH    = 2'd1,
        ST_INTERVAL = 2'd2,
        ST_RSTOUT   = 2'd3
    } tmr_state_t;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_SET  = 1'b1
    } arm_state_t;

endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
    parameter int PW = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [2:0] sel_i,
    output logic       tick_o
);
    logic [PW-1:0] div_q;
    logic [PW-1:0] lim;

    function automatic logic [PW-1:0] div_limit(input logic [2:0] s);
        int e;
        unique case (s)
            3'd0: e = 1;
            3'd1: e = 3;
            3'd2: e = 5;
            3'd3: e = 6;
            3'd4: e = 8;
            3'd5: e = 9;
            3'd6: e = 11;
            3'd7: e = 12;
        endcase
        return PW'((1 << e) - 1);
    endfunction

    assign lim    = div_limit(sel_i);
    assign tick_o = run_i && (div_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run_i || div_q >= lim) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/kwd_wrdecode.sv
module kwd_wrdecode
    import kwd_pkg::*;
(
    input  logic        bus_wr,
    input  logic        bus_word,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic        cnt_we_o,
    output logic        ctrl_we_o,
    output logic        stat_we_o,
    output logic [7:0]  data_o
);
    logic       word_wr;
    logic [7:0] key;

    assign word_wr = bus_wr && bus_word;
    assign key     = bus_wdata[15:8];
    assign data_o  = bus_wdata[7:0];

    always_comb begin
        cnt_we_o  = 1'b0;
        ctrl_we_o = 1'b0;
        stat_we_o = 1'b0;
        if (word_wr) begin
            unique case (bus_addr)
                ADDR_MAIN: begin
                    cnt_we_o  = (key == KEY_COUNT);
                    ctrl_we_o = (key == KEY_CTRL);
                end
                ADDR_STAT: stat_we_o = (key == KEY_COUNT);
                default: ;
            endcase
        end
    end

    always_comb begin
        assert_one_target_R2: assert ($countones({cnt_we_o, ctrl_we_o, stat_we_o}) <= 1);
    end

endmodule

// File: rtl/kwd_status.sv
module kwd_status
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_i,
    input  logic       we_i,
    input  logic [7:0] data_i,
    input  logic       set_i,
    output logic       flag_o,
    output logic       rste_o,
    output logic [7:0] rdata_o
);
    arm_state_t arm_q, arm_d;
    logic       clr_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= ARM_IDLE;
        else        arm_q <= arm_d;
    end

    always_comb begin
        arm_d = arm_q;
        unique case (arm_q)
            ARM_IDLE: if (rd_i && flag_o) arm_d = ARM_SET;
            ARM_SET:  if (we_i)           arm_d = ARM_IDLE;
        endcase
    end

    assign clr_ok = we_i && !data_i[7] && (arm_q == ARM_SET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            rste_o <= 1'b0;
        end else begin
            if (set_i)       flag_o <= 1'b1;
            else if (clr_ok) flag_o <= 1'b0;
            if (we_i)        rste_o <= data_i[6];
        end
    end

    assign rdata_o = {flag_o, rste_o, 1'b0, 5'b11111};

    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> ($past(arm_q) == ARM_SET));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int PRESC_W    = 12,
    parameter int RST_CYCLES = 518
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic        bus_word,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        chip_rst_o,
    output logic        irq_o
);
    localparam int PCW = $clog2(RST_CYCLES);

    tmr_state_t state_q, state_d;
    logic [7:0]     cnt_q;
    logic [2:0]     sel_q;
    logic           mode_q;
    logic [PCW-1:0] pulse_q;
    logic           irq_q;

    logic       cnt_we, ctrl_we, stat_we;
    logic [7:0] wdat;
    logic       tick, wrap, wd_wrap, iv_wrap;
    logic       run;
    logic       flag, rste;
    logic [7:0] stat_rdata;

    kwd_wrdecode u_dec (
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_we_o  (cnt_we),
        .ctrl_we_o (ctrl_we),
        .stat_we_o (stat_we),
        .data_o    (wdat)
    );

    kwd_prescaler #(.PW(PRESC_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .sel_i  (sel_q),
        .tick_o (tick)
    );

    kwd_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (bus_rd && bus_addr == ADDR_STAT),
        .we_i    (stat_we),
        .data_i  (wdat),
        .set_i   (wd_wrap),
        .flag_o  (flag),
        .rste_o  (rste),
        .rdata_o (stat_rdata)
    );

    assign wrap    = tick && (cnt_q == 8'hFF);
    assign wd_wrap = wrap && (state_q == ST_WATCH);
    assign iv_wrap = wrap && (state_q == ST_INTERVAL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF, ST_WATCH, ST_INTERVAL: begin
                if (wd_wrap) begin
                    state_d = rste ? ST_RSTOUT : ST_OFF;
                end else if (ctrl_we) begin
                    if (!wdat[6])     state_d = ST_OFF;
                    else if (wdat[7]) state_d = ST_WATCH;
                    else              state_d = ST_INTERVAL;
                end
            end
            ST_RSTOUT: if (pulse_q == '0) state_d = ST_OFF;
        endcase
    end

    // output logic
    always_comb begin
        run        = 1'b0;
        chip_rst_o = 1'b0;
        unique case (state_q)
            ST_OFF:      ;
            ST_WATCH:    run = 1'b1;
            ST_INTERVAL: run = 1'b1;
            ST_RSTOUT:   chip_rst_o = 1'b1;
        endcase
    end

    assign irq_o = irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sel_q   <= '0;
            mode_q  <= 1'b0;
            pulse_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= iv_wrap;
            if (state_q == ST_RSTOUT || wd_wrap) begin
                cnt_q  <= '0;
                sel_q  <= '0;
                mode_q <= 1'b0;
            end else begin
                if (cnt_we)    cnt_q <= wdat;
                else if (tick) cnt_q <= cnt_q + 1'b1;
                if (ctrl_we) begin
                    sel_q  <= wdat[2:0];
                    mode_q <= wdat[7];
                end
            end
            if (wd_wrap && rste)         pulse_q <= PCW'(RST_CYCLES - 1);
            else if (state_q == ST_RSTOUT && pulse_q != '0) pulse_q <= pulse_q - 1'b1;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_MAIN: bus_rdata = cnt_q;
            ADDR_CTRL: bus_rdata = {mode_q, run, 3'b000, sel_q};
            ADDR_STAT: bus_rdata = stat_rdata;
            default:   bus_rdata = 8'h00;
        endcase
    end

    assert_byte_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_word && state_q == ST_OFF) |=> $stable(cnt_q));

    assert_ivl_noflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTERVAL) |=> !$rose(flag));

    assert_rst_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_o |-> (cnt_q == 8'h00 && !run));

    assert_rst_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_rst_o) |-> flag);

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_word = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [7:0]  bus_rdata;
    logic        chip_rst_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic saw_rst = 1'b0;

    always #10 clk = ~clk;

    keyed_watchdog dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_word   (bus_word),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .chip_rst_o (chip_rst_o),
        .irq_o      (irq_o)
    );

    always @(posedge clk) if (chip_rst_o) saw_rst <= 1'b1;

    // {rd, word, addr[1:0], data[15:0], expect[7:0], req[3:0]}
    localparam int NV = 15;
    localparam logic [31:0] VEC [NV] = '{
        {1'b0, 1'b1, 2'd0, 16'h5A37, 8'h00, 4'd2},  // R2 counter load
        {1'b1, 1'b1, 2'd0, 16'h0000, 8'h37, 4'd2},
        {1'b0, 1'b1, 2'd0, 16'hA503, 8'h00, 4'd2},  // R2 control load, stopped
        {1'b1, 1'b1, 2'd1, 16'h0000, 8'h03, 4'd2},
        {1'b0, 1'b0, 2'd0, 16'h5A99, 8'h00, 4'd1},  // R1 byte write
        {1'b1, 1'b1, 2'd0, 16'h0000, 8'h37, 4'd1},
        {1'b0, 1'b1, 2'd0, 16'h3C55, 8'h00, 4'd2},  // R2 wrong key
        {1'b1, 1'b1, 2'd0, 16'h0000, 8'h37, 4'd3},  // R3 stopped, holds
        {1'b1, 1'b1, 2'd1, 16'h0000, 8'h03, 4'd2},
        {1'b0, 1'b1, 2'd0, 16'hA583, 8'h00, 4'd11}, // R11 mode bit, not enabled
        {1'b1, 1'b1, 2'd1, 16'h0000, 8'h83, 4'd11},
        {1'b0, 1'b1, 2'd0, 16'hA538, 8'h00, 4'd11}, // R11 bits 5:3 read 0
        {1'b1, 1'b1, 2'd1, 16'h0000, 8'h00, 4'd11},
        {1'b0, 1'b1, 2'd2, 16'hA57F, 8'h00, 4'd6},  // R6 wrong status key
        {1'b1, 1'b1, 2'd2, 16'h0000, 8'h1F, 4'd6}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic word, input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_word = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: got hang expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(2'd0, v); check("R10 counter", v, 8'h00);
        rd(2'd1, v); check("R10 control", v, 8'h00);
        rd(2'd2, v); check("R10 status", v, 8'h1F);
        check("R10 chip_rst", {7'd0, chip_rst_o}, 8'h00);
        check("R10 irq", {7'd0, irq_o}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][31]) begin
                rd(VEC[i][29:28], v);
                check($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][11:4]);
            end else begin
                wr(VEC[i][30], VEC[i][29:28], VEC[i][27:12]);
            end
        end

        // R6 reset-enable write, fixed low bits
        wr(1'b1, 2'd2, 16'h5A7F);
        rd(2'd2, v); check("R6 status rste", v, 8'h5F);

        // R7 / R4 watchdog wrap with reset enabled, divide by 2
        wr(1'b1, 2'd0, 16'h5AFD);
        wr(1'b1, 2'd0, 16'hA5C0);          // edge E0
        repeat (5) @(negedge clk);
        check("R7 no pulse before wrap", {7'd0, chip_rst_o}, 8'h00);
        @(negedge clk);
        check("R7 pulse after wrap", {7'd0, chip_rst_o}, 8'h01);
        rd(2'd0, v); check("R7 counter in pulse", v, 8'h00);
        rd(2'd1, v); check("R7 control in pulse", v, 8'h00);
        n = 2;
        while (chip_rst_o && n < 700) begin
            n++;
            @(negedge clk);
        end
        check("R7 pulse length lo", n[7:0], 8'(518));
        check("R7 pulse length hi", n[15:8], 8'(518 >> 8));

        // R5 clear handshake
        wr(1'b1, 2'd2, 16'h5A40);
        rd(2'd2, v); check("R5 flag kept without read", v, 8'hDF);
        wr(1'b1, 2'd2, 16'h5A00);
        rd(2'd2, v); check("R5 flag cleared after read", v, 8'h1F);

        // R8 / R3 watchdog wrap, reset disabled, divide by 8
        saw_rst = 1'b0;
        wr(1'b1, 2'd0, 16'h5AFE);
        wr(1'b1, 2'd0, 16'hA5C1);          // edge E0
        repeat (7) @(negedge clk);
        rd(2'd0, v); check("R3 before first step", v, 8'hFE);
        rd(2'd0, v); check("R3 step after 8 clocks", v, 8'hFF);
        repeat (6) @(negedge clk);
        rd(2'd1, v); check("R8 control still running", v, 8'hC1);
        rd(2'd1, v); check("R8 control cleared", v, 8'h00);
        rd(2'd0, v); check("R8 counter cleared", v, 8'h00);
        rd(2'd2, v); check("R4 flag set by watchdog", v, 8'h9F);
        check("R8 no chip reset", {7'd0, saw_rst}, 8'h00);

        wr(1'b1, 2'd2, 16'h5A00);
        rd(2'd2, v); check("R5 flag cleared again", v, 8'h1F);

        // R9 / R4 interval mode, divide by 2
        wr(1'b1, 2'd0, 16'h5AFF);
        wr(1'b1, 2'd0, 16'hA540);          // edge E0
        check("R9 irq idle", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        check("R9 irq not early", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        check("R9 irq pulse", {7'd0, irq_o}, 8'h01);
        @(negedge clk);
        check("R9 irq one clock", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        rd(2'd0, v); check("R9 counter keeps running", v, 8'h01);
        rd(2'd2, v); check("R4 no flag in interval", v, 8'h1F);
        rd(2'd1, v); check("R9 still enabled", v, 8'h40);
        wr(1'b1, 2'd0, 16'hA500);

        finish_run();
    end

endmodule